// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen maskable interrupt sources and two non-maskable entries, and gives a CPU core one request line plus the address of the vector to fetch. Three external edge pins, two counter-pin edges, an eight-pin key group and nine single-cycle internal pulses (serial port, a 16-bit timer, six 8-bit timers, A-D converter) each set a request bit. A request bit can only be set by hardware. Software can clear it, enable or mask each source, pick the edge polarity per pin and control a global disable flag through a small register bus.

The request line is raised for the highest-priority source whose request and enable are both set while the disable flag is clear. The power-on entry and the software break entry bypass every mask. When the core pulses the accept input while the request line is high, the winning entry is retired and the disable flag is set. Every external pin passes through two synchronizing flops before edge detection.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the power-on entry is pending, so irq_o is 1 with vec_o = 0xFFFC. The request, enable and edge registers read 0. The disable flag reads 1.
- R2: A maskable source raises irq_o only when its request bit and its enable bit are both 1 and the disable flag is 0.
- R3: A register write of 0 to a request bit clears it, and a write of 1 leaves it unchanged. A hardware set in the same cycle as a software clear wins, and the bit stays 1.
- R4: Request and enable bit positions follow priority, highest first. Address 0 holds bit0 INT0, bit1 INT1, bit2 INT2, bit3 serial, bit4 16-bit timer, bits 5-7 timers 1-3. Address 1 holds bits 0-2 timers 4-6, bit3 counter pin 0, bit4 counter pin 1, bit5 key group, bit6 A-D, and bit7 reads 0. Priority level L counts 0 for power-on, 1 to 15 for these sources in order, and 16 for break. vec_o = 0xFFFC - 2*L while irq_o is 1, and 0 otherwise.
- R5: When ack_i is 1 in a cycle with irq_o high, the winning entry is cleared and the disable flag reads 1 from the next cycle on.
- R6: Edge register bits 0-2 set the polarity of ext_i[0..2] (0 falling, 1 rising). A qualifying pin edge sets the request bit on the third rising clock edge after the pin changes.
- R7: Edge register bits 6 and 7 set the polarity of cnt_i[0] and cnt_i[1], with the same timing as R6. Bits 3-5 of the edge register always read 0.
- R8: The key request is set when the AND of the synchronized key pins whose key_out_i bit is 0 falls from 1 to 0. Pins with key_out_i = 1 are left out of the AND.
- R9: Changing a polarity bit so that the pin's present level becomes the post-edge level sets that request bit one cycle later. A change the other way sets nothing.
- R10: The power-on and break entries raise irq_o regardless of the disable flag and the enable bits. A brk_i pulse makes the break entry pending, with vec_o = 0xFFDC when no other entry wins.
- R11: Register addresses are 0 and 1 for request low/high, 2 and 3 for enable low/high, 4 for edge select and 5 for the disable flag in bit0. Other addresses read 0. The enable high byte bit7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_i | input | 3 | External edge interrupt pins |
| cnt_i | input | 2 | Counter pin edge inputs |
| key_i | input | KEYW | Key group pins |
| key_out_i | input | KEYW | Per-pin output mode (1 = excluded from AND) |
| int_i | input | 9 | Internal pulses: bit0 serial, bit1 16-bit timer, bits 2-7 timers 1-6, bit8 A-D |
| brk_i | input | 1 | Software break pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| ack_i | input | 1 | Accept from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector low-byte address of the winner |

## Verification
The bench goes after a software clear that lands in the same cycle as a hardware set. A design that lets the clear win would lose that interrupt. It also rewrites a polarity bit while the pin is static, in both directions. A wrong design either misses the documented spurious request or raises one on the harmless direction. The key group is driven low only on pins in output mode, and a design that left those pins in the AND would raise a false wake request. Accepting a stack of simultaneous pulses one at a time catches a wrong priority order or vector step, and masking everything before a break pulse shows whether the non-maskable path honours the flag by mistake.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NEXT = 3;
  localparam int NCNT = 2;
  localparam int NINT = 9;
  localparam int NSRC = NEXT + NINT + NCNT + 1;
  localparam int LVLW = $clog2(NSRC + 2);
  localparam logic [15:0] VEC_TOP = 16'hFFFC;

  localparam int SRC_CNT0 = 11;
  localparam int SRC_KEY  = 13;
  localparam int SRC_ADC  = 14;

  localparam logic [2:0] A_REQ_LO = 3'd0;
  localparam logic [2:0] A_REQ_HI = 3'd1;
  localparam logic [2:0] A_EN_LO  = 3'd2;
  localparam logic [2:0] A_EN_HI  = 3'd3;
  localparam logic [2:0] A_EDGE   = 3'd4;
  localparam logic [2:0] A_DIS    = 3'd5;
  localparam logic [7:0] EDGE_MASK = 8'hC7;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] s1_q, s2_q, lv_q, lv;

  // active level: pin for rising, inverted pin for falling
  assign lv    = ~(s2_q ^ pol_i);
  assign hit_o = lv & ~lv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      lv_q <= '1;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      lv_q <= lv;
    end
  end
endmodule

// File: rtl/irq_key_det.sv
module irq_key_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] key_i,
  input  logic [W-1:0] out_i,
  output logic         fall_o
);
  logic [W-1:0] s1_q, s2_q;
  logic         and_q, and_now;

  assign and_now = &(s2_q | out_i);
  assign fall_o  = and_q & ~and_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      and_q <= 1'b0;
    end else begin
      s1_q  <= key_i;
      s2_q  <= s1_q;
      and_q <= and_now;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N    = 15,
  parameter int LVLW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    pend_i,
  input  logic            dis_i,
  input  logic            rst_p_i,
  input  logic            brk_p_i,
  output logic [N-1:0]    grant_o,
  output logic            rst_g_o,
  output logic            brk_g_o,
  output logic            any_o,
  output logic [LVLW-1:0] lvl_o
);
  logic [N-1:0] live;
  logic         found;

  assign live = dis_i ? '0 : pend_i;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    lvl_o   = LVLW'(N + 1);
    for (int i = 0; i < N; i++) begin
      if (live[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
        lvl_o      = LVLW'(i + 1);
      end
    end
    if (rst_p_i) begin
      grant_o = '0;
      lvl_o   = '0;
    end
  end

  assign rst_g_o = rst_p_i;
  assign brk_g_o = !rst_p_i && !found && brk_p_i;
  assign any_o   = rst_p_i || found || brk_p_i;

  a_r4_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, rst_g_o, brk_g_o}));
  a_r4_any_has_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ($countones({grant_o, rst_g_o, brk_g_o}) == 1));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int KEYW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] ext_i,
  input  logic [NCNT-1:0] cnt_i,
  input  logic [KEYW-1:0] key_i,
  input  logic [KEYW-1:0] key_out_i,
  input  logic [NINT-1:0] int_i,
  input  logic            brk_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [15:0]     vec_o
);
  localparam int NPIN = NEXT + NCNT;

  logic [NSRC-1:0] req_q, en_q, set_v, sw_clr, ack_clr, grant;
  logic [7:0]      pol_q;
  logic            dis_q, rst_p_q, brk_p_q;
  logic [NPIN-1:0] pin_hit;
  logic            key_fall, rst_g, brk_g, any, take;
  logic [LVLW-1:0] lvl;

  irq_edge_det #(.W(NPIN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({cnt_i, ext_i}),
    .pol_i  ({pol_q[7:6], pol_q[2:0]}),
    .hit_o  (pin_hit)
  );

  irq_key_det #(.W(KEYW)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .key_i  (key_i),
    .out_i  (key_out_i),
    .fall_o (key_fall)
  );

  irq_prio #(.N(NSRC), .LVLW(LVLW)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (req_q & en_q),
    .dis_i   (dis_q),
    .rst_p_i (rst_p_q),
    .brk_p_i (brk_p_q),
    .grant_o (grant),
    .rst_g_o (rst_g),
    .brk_g_o (brk_g),
    .any_o   (any),
    .lvl_o   (lvl)
  );

  // source positions follow priority order
  assign set_v = {int_i[8], key_fall, pin_hit[NPIN-1:NEXT], int_i[7:0], pin_hit[NEXT-1:0]};

  always_comb begin
    sw_clr = '0;
    if (we_i && addr_i == A_REQ_LO) sw_clr[7:0] = ~wdata_i;
    if (we_i && addr_i == A_REQ_HI) sw_clr[NSRC-1:8] = ~wdata_i[NSRC-9:0];
  end

  assign take    = ack_i && irq_o;
  assign ack_clr = take ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      en_q    <= '0;
      pol_q   <= '0;
      dis_q   <= 1'b1;
      rst_p_q <= 1'b1;
      brk_p_q <= 1'b0;
    end else begin
      req_q <= (req_q & ~sw_clr & ~ack_clr) | set_v;
      if (we_i && addr_i == A_EN_LO) en_q[7:0] <= wdata_i;
      if (we_i && addr_i == A_EN_HI) en_q[NSRC-1:8] <= wdata_i[NSRC-9:0];
      if (we_i && addr_i == A_EDGE)  pol_q <= wdata_i & EDGE_MASK;
      if (take)                        dis_q <= 1'b1;
      else if (we_i && addr_i == A_DIS) dis_q <= wdata_i[0];
      if (take && rst_g) rst_p_q <= 1'b0;
      if (brk_i)              brk_p_q <= 1'b1;
      else if (take && brk_g) brk_p_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_REQ_LO: rdata_o = req_q[7:0];
      A_REQ_HI: rdata_o = {1'b0, req_q[NSRC-1:8]};
      A_EN_LO:  rdata_o = en_q[7:0];
      A_EN_HI:  rdata_o = {1'b0, en_q[NSRC-1:8]};
      A_EDGE:   rdata_o = pol_q;
      A_DIS:    rdata_o = {7'b0, dis_q};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = any;
  assign vec_o = any ? VEC_TOP - {{(15 - LVLW){1'b0}}, lvl, 1'b0} : '0;

  a_r2_mask_honoured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rst_g && !brk_g) |-> !dis_q);
  a_r5_accept_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> dis_q);
  a_r10_power_on_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_p_q |-> (irq_o && vec_o == VEC_TOP));
  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_REQ_LO && set_v[7:0] == 8'h00) |=>
      ((req_q[7:0] & ~$past(req_q[7:0])) == 8'h00));
  a_r8_key_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_fall |=> req_q[SRC_KEY]);
  a_r7_cnt_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_hit[NEXT] |=> req_q[SRC_CNT0]);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext = '0;
  logic [1:0]  cnt = '0;
  logic [7:0]  key = '0;
  logic [7:0]  key_out = '0;
  logic [8:0]  intp = '0;
  logic        brk = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack = 1'b0;
  logic [7:0]  rdata;
  logic        irq;
  logic [15:0] vec;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    ended = 0;

  always #10 clk = ~clk;

  irq_ctrl #(.KEYW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_i(ext), .cnt_i(cnt), .key_i(key),
    .key_out_i(key_out), .int_i(intp), .brk_i(brk), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  // behavioural reference
  int m_req[15], m_en[15], m_pol[8];
  int m_dis, m_rp, m_bp;
  int ph1[5], ph2[5], m_lvp[5];
  int kh1[8], kh2[8], m_kand;

  function automatic int pin_src(int p);
    return (p < 3) ? p : p + 8;
  endfunction

  function automatic int pin_pol(int p);
    return (p < 3) ? p : p + 3;
  endfunction

  function automatic int m_win();
    if (m_rp != 0) return 0;
    if (m_dis == 0)
      for (int s = 0; s < 15; s++)
        if (m_req[s] != 0 && m_en[s] != 0) return s + 1;
    if (m_bp != 0) return 16;
    return -1;
  endfunction

  function automatic int m_rd(int a);
    int v;
    v = 0;
    case (a)
      0: for (int b = 0; b < 8; b++) v += m_req[b] << b;
      1: for (int b = 0; b < 7; b++) v += m_req[b+8] << b;
      2: for (int b = 0; b < 8; b++) v += m_en[b] << b;
      3: for (int b = 0; b < 7; b++) v += m_en[b+8] << b;
      4: for (int b = 0; b < 8; b++) v += m_pol[b] << b;
      5: v = m_dis;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 15; s++) begin m_req[s] = 0; m_en[s] = 0; end
      for (int b = 0; b < 8; b++) begin m_pol[b] = 0; kh1[b] = 0; kh2[b] = 0; end
      for (int p = 0; p < 5; p++) begin ph1[p] = 0; ph2[p] = 0; m_lvp[p] = 1; end
      m_dis = 1; m_rp = 1; m_bp = 0; m_kand = 0;
    end else begin
      int w, kand, lv;
      int setv[15], clr[15], nlv[5];
      w = m_win();
      for (int s = 0; s < 15; s++) begin setv[s] = 0; clr[s] = 0; end
      for (int p = 0; p < 5; p++) begin
        lv = (m_pol[pin_pol(p)] != 0) ? ph2[p] : 1 - ph2[p];
        if (lv == 1 && m_lvp[p] == 0) setv[pin_src(p)] = 1;
        nlv[p] = lv;
      end
      kand = 1;
      for (int k = 0; k < 8; k++) if (!key_out[k] && kh2[k] == 0) kand = 0;
      if (m_kand == 1 && kand == 0) setv[13] = 1;
      setv[3] = intp[0];
      setv[4] = intp[1];
      for (int j = 0; j < 6; j++) setv[5+j] = intp[2+j];
      setv[14] = intp[8];
      if (we && addr == 0) for (int b = 0; b < 8; b++) if (!wdata[b]) clr[b] = 1;
      if (we && addr == 1) for (int b = 0; b < 7; b++) if (!wdata[b]) clr[b+8] = 1;
      if (ack && w >= 1 && w <= 15) clr[w-1] = 1;
      for (int s = 0; s < 15; s++) m_req[s] = ((m_req[s] != 0 && clr[s] == 0) || setv[s] != 0) ? 1 : 0;
      if (ack && w == 0) m_rp = 0;
      if (brk) m_bp = 1;
      else if (ack && w == 16) m_bp = 0;
      if (ack && w >= 0) m_dis = 1;
      else if (we && addr == 5) m_dis = wdata[0];
      if (we && addr == 2) for (int b = 0; b < 8; b++) m_en[b] = wdata[b];
      if (we && addr == 3) for (int b = 0; b < 7; b++) m_en[b+8] = wdata[b];
      if (we && addr == 4) for (int b = 0; b < 8; b++) m_pol[b] = (b >= 3 && b <= 5) ? 0 : wdata[b];
      for (int p = 0; p < 5; p++) begin
        ph2[p] = ph1[p];
        ph1[p] = (p < 3) ? ext[p] : cnt[p-3];
        m_lvp[p] = nlv[p];
      end
      for (int k = 0; k < 8; k++) begin kh2[k] = kh1[k]; kh1[k] = key[k]; end
      m_kand = kand;
    end
  end

  // cycle-by-cycle compare
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      int w, ev, ei;
      w  = m_win();
      ei = (w >= 0) ? 1 : 0;
      ev = (w >= 0) ? 16'hFFFC - 2 * w : 0;
      n_vec++;
      if (irq !== ei[0] || vec !== ev[15:0] || rdata !== m_rd(addr)) begin
        n_bad++;
        $display("FAIL %s model: irq=%0d/%0d vec=%h/%h rdata=%h/%h",
                 cur_req, irq, ei, vec, ev[15:0], rdata, m_rd(addr));
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, int exp, string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    tick();
  endtask

  task automatic acc();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic out_chk(string tag, int ei, int ev);
    @(negedge clk);
    chk(tag, irq, ei);
    chk(tag, vec, ev);
    tick();
  endtask

  task automatic finish_run();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    cur_req = "R1";
    out_chk("R1 power-on vector", 1, 16'hFFFC);
    rd_chk(5, 1, "R1 disable flag");
    rd_chk(0, 0, "R1 request low");
    rd_chk(4, 0, "R1 edge reg");

    cur_req = "R10";
    acc();
    out_chk("R10 power-on retired", 0, 0);
    rd_chk(5, 1, "R5 flag after accept");

    cur_req = "R11";
    wr(2, 8'hFF);
    wr(3, 8'hFF);
    rd_chk(3, 8'h7F, "R11 enable high bit7");
    wr(4, 8'hFF);
    rd_chk(4, 8'hC7, "R7 edge bits 3-5 zero");
    rd_chk(6, 0, "R11 unused address");

    cur_req = "R6";
    ext[1] = 1'b1;
    idle(3);
    ext[1] = 1'b0;
    rd_chk(0, 8'h02, "R6 rising INT1");
    wr(5, 8'h00);
    out_chk("R6 INT1 vector", 1, 16'hFFF8);

    cur_req = "R5";
    acc();
    out_chk("R5 after accept", 0, 0);
    rd_chk(0, 0, "R5 request cleared");
    rd_chk(5, 1, "R5 flag set");

    cur_req = "R4";
    intp = 9'h1FF;
    tick();
    intp = '0;
    wr(5, 8'h00);
    for (int s = 3; s <= 14; s++) begin
      if (s <= 10 || s == 14) begin
        out_chk("R4 priority order", 1, 16'hFFFC - 2 * (s + 1));
        acc();
        wr(5, 8'h00);
      end
    end
    out_chk("R4 all retired", 0, 0);

    cur_req = "R3";
    wr(5, 8'h01);
    intp[0] = 1'b1;
    wr(0, 8'h00);
    intp[0] = 1'b0;
    rd_chk(0, 8'h08, "R3 set beats clear");
    wr(0, 8'hFF);
    rd_chk(0, 8'h08, "R3 write one no effect");
    wr(0, 8'hF7);
    rd_chk(0, 8'h00, "R3 write zero clears");

    cur_req = "R7";
    cnt[1] = 1'b1;
    idle(3);
    cnt[1] = 1'b0;
    rd_chk(1, 8'h10, "R7 counter pin 1 rising");
    wr(1, 8'hEF);
    rd_chk(1, 8'h00, "R7 cleared");

    cur_req = "R9";
    ext[0] = 1'b1;
    idle(3);
    wr(0, 8'hFE);
    wr(4, 8'hC6);
    idle(1);
    rd_chk(0, 8'h00, "R9 harmless polarity change");
    wr(4, 8'hC7);
    idle(1);
    rd_chk(0, 8'h01, "R9 spurious request");
    wr(0, 8'hFE);
    ext[0] = 1'b0;
    idle(3);
    rd_chk(0, 8'h00, "R6 falling ignored when rising");

    cur_req = "R8";
    key = 8'hFF;
    idle(3);
    key_out = 8'hF0;
    key = 8'h0F;
    idle(3);
    rd_chk(1, 8'h00, "R8 output pins excluded");
    key[2] = 1'b0;
    idle(3);
    rd_chk(1, 8'h20, "R8 key fall");
    wr(1, 8'hDF);

    cur_req = "R2";
    wr(2, 8'h00);
    intp[1] = 1'b1;
    tick();
    intp[1] = 1'b0;
    wr(5, 8'h00);
    out_chk("R2 disabled source silent", 0, 0);
    wr(2, 8'h10);
    out_chk("R2 enabled source", 1, 16'hFFF2);
    acc();

    cur_req = "R10";
    wr(2, 8'h00);
    wr(3, 8'h00);
    brk = 1'b1;
    tick();
    brk = 1'b0;
    out_chk("R10 break unmasked", 1, 16'hFFDC);
    acc();
    out_chk("R10 break retired", 0, 0);

    finish_run();
  end
endmodule